// File: doc/BRIEF.md
# Transmit Confirmation Generator

This block reports how each outgoing asynchronous packet ended. When the link transmitter signals that a packet has left, the block takes the packet's class (request or response), its destination node ID, its transaction label, a broadcast flag and the acknowledge outcome seen on the bus. From these it builds one 32-bit confirmation word. That word goes to the receive-side queue that matches the packet class, so software can pair each transmission with its result.

The transmitter side uses a valid/ready handshake. The block holds at most one confirmation at a time. While that confirmation is waiting for its queue, the block stops taking new transmit-done events, so no result can be dropped.

Top module: `txconf_gen`

## Requirements
- R1: Every transmit-done event accepted (done_valid and done_ready high at a clock edge) produces exactly one confirmation write (wvalid and wready high at an edge), and no write happens without an accepted event.
- R2: A confirmation for a request (done_is_resp=0) is offered only on the request queue port. A confirmation for a response (done_is_resp=1) is offered only on the response queue port. The two wvalid outputs are never high together.
- R3: The confirmation word carries the destination node ID in bits 31:16, the transaction label in bits 15:10, zeros in bits 9:4 and the confirmation code in bits 3:0.
- R4: A non-broadcast packet with outcome 0 (no acknowledge) gives code 0x0.
- R5: A broadcast packet gives code 0x1 whatever the outcome input holds.
- R6: A non-broadcast packet gives code 0x1 for outcome 1 (ack complete) and code 0x2 for outcome 2 (ack pending).
- R7: A non-broadcast packet with outcome 5 (retry limit exhausted) gives code 0x4.
- R8: A non-broadcast packet gives code 0xD for outcome 3 (ack data error) and code 0xE for outcome 4 (ack type error).
- R9: Outcome values 6 and 7 are treated as no acknowledge (code 0x0). The output code is never outside the set {0x0, 0x1, 0x2, 0x4, 0xD, 0xE}.
- R10: While a confirmation is offered but not taken, done_ready stays low, and wvalid and wdata stay unchanged.
- R11: After reset, neither wvalid is high and done_ready is high. Events presented during reset are not accepted.
- R12: A confirmation is offered on its queue port in the clock cycle after its event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_valid | input | 1 | Transmit-done event present |
| done_ready | output | 1 | Block can accept an event |
| done_is_resp | input | 1 | 1 = response packet, 0 = request packet |
| done_dest | input | 16 | Destination node ID |
| done_tlabel | input | 6 | Transaction label |
| done_bcast | input | 1 | Packet was broadcast |
| done_ack | input | 3 | Acknowledge outcome code (0..7) |
| req_wvalid | output | 1 | Confirmation offered to the request queue |
| req_wdata | output | 32 | Confirmation word for the request queue |
| req_wready | input | 1 | Request queue can take a word |
| rsp_wvalid | output | 1 | Confirmation offered to the response queue |
| rsp_wdata | output | 32 | Confirmation word for the response queue |
| rsp_wready | input | 1 | Response queue can take a word |

## Verification
Several properties are checked on every cycle. These are: that the two queue ports are never offered a word together, that a stalled word stays frozen and blocks new events, that every accepted event appears next cycle on the correct port with its node ID and label, that broadcasts always carry code 0x1, and that no reserved code appears. Other matters can be shown only by the bench's scenarios, which drive a reference model. These are: the exact code for each outcome value, including the values 6 and 7, and the equal count of events and writes when queue readiness changes at random over long runs.

// File: rtl/txconf_pkg.sv
package txconf_pkg;

  typedef enum logic [2:0] {
    ACK_NONE     = 3'd0,
    ACK_COMPLETE = 3'd1,
    ACK_PENDING  = 3'd2,
    ACK_DATA_ERR = 3'd3,
    ACK_TYPE_ERR = 3'd4,
    ACK_RETRY_EX = 3'd5
  } ack_outcome_e;

  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] CC_NO_ACK   = 4'h0;
  localparam logic [CODE_W-1:0] CC_COMPLETE = 4'h1;
  localparam logic [CODE_W-1:0] CC_PENDING  = 4'h2;
  localparam logic [CODE_W-1:0] CC_RETRY_EX = 4'h4;
  localparam logic [CODE_W-1:0] CC_DATA_ERR = 4'hD;
  localparam logic [CODE_W-1:0] CC_TYPE_ERR = 4'hE;

  localparam int NUM_Q = 2;
  localparam int Q_REQ = 0;
  localparam int Q_RSP = 1;

endpackage

// File: rtl/txconf_code_map.sv
module txconf_code_map
  import txconf_pkg::*;
(
  input  logic              bcast,
  input  logic [2:0]        ack,
  output logic [CODE_W-1:0] code
);

  always_comb begin
    if (bcast) begin
      code = CC_COMPLETE;
    end else begin
      case (ack)
        ACK_COMPLETE: code = CC_COMPLETE;
        ACK_PENDING:  code = CC_PENDING;
        ACK_DATA_ERR: code = CC_DATA_ERR;
        ACK_TYPE_ERR: code = CC_TYPE_ERR;
        ACK_RETRY_EX: code = CC_RETRY_EX;
        default:      code = CC_NO_ACK;
      endcase
    end
  end

endmodule

// File: rtl/txconf_word_pack.sv
module txconf_word_pack
  import txconf_pkg::*;
#(
  parameter int NODE_W  = 16,
  parameter int LABEL_W = 6,
  parameter int WORD_W  = 32
) (
  input  logic [NODE_W-1:0]  dest,
  input  logic [LABEL_W-1:0] tlabel,
  input  logic [CODE_W-1:0]  code,
  output logic [WORD_W-1:0]  word
);

  localparam int PAD_W = WORD_W - NODE_W - LABEL_W - CODE_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word = {dest, tlabel, {PAD_W{1'b0}}, code};
    end else begin : g_nopad
      assign word = {dest, tlabel, code};
    end
  endgenerate

endmodule

// File: rtl/txconf_hold.sv
module txconf_hold
  import txconf_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_resp,
  input  logic [WORD_W-1:0] load_word,
  input  logic [NUM_Q-1:0]  q_ready,
  output logic [NUM_Q-1:0]  q_valid,
  output logic [WORD_W-1:0] q_word,
  output logic              busy
);

  logic [NUM_Q-1:0] sel;
  logic [NUM_Q-1:0] vld_q;
  logic [WORD_W-1:0] word_q;

  genvar gq;
  generate
    for (gq = 0; gq < NUM_Q; gq++) begin : g_sel
      assign sel[gq] = (gq == Q_RSP) ? load_resp : !load_resp;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      word_q <= '0;
    end else if (load) begin
      vld_q  <= sel;
      word_q <= load_word;
    end else if (|(vld_q & q_ready)) begin
      vld_q  <= '0;
    end
  end

  assign q_valid = vld_q;
  assign q_word  = word_q;
  assign busy    = |vld_q;

endmodule

// File: rtl/txconf_gen.sv
module txconf_gen
  import txconf_pkg::*;
#(
  parameter int NODE_W  = 16,
  parameter int LABEL_W = 6,
  parameter int WORD_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               done_valid,
  output logic               done_ready,
  input  logic               done_is_resp,
  input  logic [NODE_W-1:0]  done_dest,
  input  logic [LABEL_W-1:0] done_tlabel,
  input  logic               done_bcast,
  input  logic [2:0]         done_ack,
  output logic               req_wvalid,
  output logic [WORD_W-1:0]  req_wdata,
  input  logic               req_wready,
  output logic               rsp_wvalid,
  output logic [WORD_W-1:0]  rsp_wdata,
  input  logic               rsp_wready
);

  logic [CODE_W-1:0] code;
  logic [WORD_W-1:0] new_word;
  logic [WORD_W-1:0] held_word;
  logic [NUM_Q-1:0]  q_valid;
  logic [NUM_Q-1:0]  q_ready;
  logic              busy;
  logic              load;

  txconf_code_map u_map (
    .bcast (done_bcast),
    .ack   (done_ack),
    .code  (code)
  );

  txconf_word_pack #(
    .NODE_W  (NODE_W),
    .LABEL_W (LABEL_W),
    .WORD_W  (WORD_W)
  ) u_pack (
    .dest   (done_dest),
    .tlabel (done_tlabel),
    .code   (code),
    .word   (new_word)
  );

  assign load = done_valid && !busy;

  assign q_ready[Q_REQ] = req_wready;
  assign q_ready[Q_RSP] = rsp_wready;

  txconf_hold #(
    .WORD_W (WORD_W)
  ) u_hold (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_resp (done_is_resp),
    .load_word (new_word),
    .q_ready   (q_ready),
    .q_valid   (q_valid),
    .q_word    (held_word),
    .busy      (busy)
  );

  assign done_ready = !busy;
  assign req_wvalid = q_valid[Q_REQ];
  assign rsp_wvalid = q_valid[Q_RSP];
  assign req_wdata  = held_word;
  assign rsp_wdata  = held_word;

endmodule

// File: rtl/txconf_gen_chk.sv
module txconf_gen_chk #(
  parameter int NODE_W  = 16,
  parameter int LABEL_W = 6,
  parameter int WORD_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               done_valid,
  input logic               done_ready,
  input logic               done_is_resp,
  input logic [NODE_W-1:0]  done_dest,
  input logic [LABEL_W-1:0] done_tlabel,
  input logic               done_bcast,
  input logic               req_wvalid,
  input logic [WORD_W-1:0]  req_wdata,
  input logic               req_wready,
  input logic               rsp_wvalid,
  input logic [WORD_W-1:0]  rsp_wdata,
  input logic               rsp_wready
);

  localparam int TOP_LO = WORD_W - NODE_W;
  localparam int LBL_LO = TOP_LO - LABEL_W;

  logic              any_v;
  logic [WORD_W-1:0] out_w;
  logic              accept;

  assign any_v  = req_wvalid || rsp_wvalid;
  assign out_w  = req_wvalid ? req_wdata : rsp_wdata;
  assign accept = done_valid && done_ready;

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
    !(req_wvalid && rsp_wvalid)); // R2

  AST_ROUTE_REQ: assert property (@(posedge clk) disable iff (rst)
    accept && !done_is_resp |=> req_wvalid && !rsp_wvalid); // R2

  AST_ROUTE_RSP: assert property (@(posedge clk) disable iff (rst)
    accept && done_is_resp |=> rsp_wvalid && !req_wvalid); // R2

  AST_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    accept |=> any_v); // R12

  AST_FIELDS: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_w[WORD_W-1:TOP_LO] == $past(done_dest)
           && out_w[TOP_LO-1:LBL_LO] == $past(done_tlabel)); // R3

  AST_BCAST_CODE: assert property (@(posedge clk) disable iff (rst)
    accept && done_bcast |=> out_w[3:0] == 4'h1); // R5

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    any_v |-> (out_w[3:0] inside {4'h0, 4'h1, 4'h2, 4'h4, 4'hD, 4'hE})); // R9

  AST_BLOCK_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
    any_v |-> !done_ready); // R10

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    req_wvalid && !req_wready |=> req_wvalid && $stable(req_wdata)); // R10

  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (rst)
    rsp_wvalid && !rsp_wready |=> rsp_wvalid && $stable(rsp_wdata)); // R10

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !any_v && !accept |=> !any_v); // R1

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !req_wvalid && !rsp_wvalid && done_ready); // R11

endmodule

bind txconf_gen txconf_gen_chk #(
  .NODE_W  (NODE_W),
  .LABEL_W (LABEL_W),
  .WORD_W  (WORD_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .done_valid   (done_valid),
  .done_ready   (done_ready),
  .done_is_resp (done_is_resp),
  .done_dest    (done_dest),
  .done_tlabel  (done_tlabel),
  .done_bcast   (done_bcast),
  .req_wvalid   (req_wvalid),
  .req_wdata    (req_wdata),
  .req_wready   (req_wready),
  .rsp_wvalid   (rsp_wvalid),
  .rsp_wdata    (rsp_wdata),
  .rsp_wready   (rsp_wready)
);

// File: tb/txconf_gen_test.sv
module txconf_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        done_valid = 1'b0;
  logic        done_ready;
  logic        done_is_resp = 1'b0;
  logic [15:0] done_dest = '0;
  logic [5:0]  done_tlabel = '0;
  logic        done_bcast = 1'b0;
  logic [2:0]  done_ack = '0;
  logic        req_wvalid, rsp_wvalid;
  logic [31:0] req_wdata, rsp_wdata;
  logic        req_wready = 1'b1;
  logic        rsp_wready = 1'b1;

  always #4 clk = ~clk;

  txconf_gen uut (
    .clk(clk), .rst(rst),
    .done_valid(done_valid), .done_ready(done_ready),
    .done_is_resp(done_is_resp), .done_dest(done_dest),
    .done_tlabel(done_tlabel), .done_bcast(done_bcast), .done_ack(done_ack),
    .req_wvalid(req_wvalid), .req_wdata(req_wdata), .req_wready(req_wready),
    .rsp_wvalid(rsp_wvalid), .rsp_wdata(rsp_wdata), .rsp_wready(rsp_wready)
  );

  int    total = 0;
  int    bad = 0;
  int    accepts = 0;
  int    writes = 0;
  int    cycles = 0;
  bit    random_ready = 1'b0;
  bit    finished = 1'b0;
  string cur_tag = "R11";
  logic [15:0] lfsr = 16'hACE1;

  // Reference model: one pending confirmation slot
  bit          m_valid = 1'b0;
  bit          m_resp = 1'b0;
  logic [31:0] m_word = '0;

  function automatic logic [3:0] exp_code(input bit bc, input int ack);
    if (bc) return 4'h1;
    if (ack == 1) return 4'h1;
    if (ack == 2) return 4'h2;
    if (ack == 3) return 4'hD;
    if (ack == 4) return 4'hE;
    if (ack == 5) return 4'h4;
    return 4'h0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst && done_valid && done_ready) accepts <= accepts + 1;
    if (!rst && ((req_wvalid && req_wready) || (rsp_wvalid && rsp_wready))) writes <= writes + 1;
    if (rst) begin
      m_valid <= 1'b0;
    end else if (m_valid) begin
      if (m_resp ? rsp_wready : req_wready) m_valid <= 1'b0;
    end else if (done_valid) begin
      m_valid <= 1'b1;
      m_resp  <= done_is_resp;
      m_word  <= {done_dest, done_tlabel, 6'b0, exp_code(done_bcast, int'(done_ack))};
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(done_ready == !m_valid, {cur_tag, " R10 done_ready"},
            {31'b0, done_ready}, {31'b0, !m_valid});
      check(req_wvalid == (m_valid && !m_resp), {cur_tag, " R2 req_wvalid"},
            {31'b0, req_wvalid}, {31'b0, m_valid && !m_resp});
      check(rsp_wvalid == (m_valid && m_resp), {cur_tag, " R2 rsp_wvalid"},
            {31'b0, rsp_wvalid}, {31'b0, m_valid && m_resp});
      if (m_valid)
        check((m_resp ? rsp_wdata : req_wdata) === m_word, {cur_tag, " R3 word"},
              m_resp ? rsp_wdata : req_wdata, m_word);
    end
    if (random_ready) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_wready <= lfsr[0] | lfsr[3];
      rsp_wready <= lfsr[5];
    end
  end

  task automatic send(input bit resp, input logic [15:0] dest, input logic [5:0] tl,
                      input bit bc, input logic [2:0] ack);
    done_is_resp = resp;
    done_dest    = dest;
    done_tlabel  = tl;
    done_bcast   = bc;
    done_ack     = ack;
    done_valid   = 1'b1;
    while (!done_ready) @(negedge clk);
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic drain();
    while (req_wvalid || rsp_wvalid) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    // R11: event presented during reset must not be taken
    done_valid = 1'b1;
    repeat (4) @(negedge clk);
    check(!req_wvalid && !rsp_wvalid, "R11 no wvalid in reset", {30'b0, rsp_wvalid, req_wvalid}, 32'd0);
    check(done_ready === 1'b1, "R11 done_ready after reset", {31'b0, done_ready}, 32'd1);
    done_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(!req_wvalid && !rsp_wvalid, "R11 idle after reset", {30'b0, rsp_wvalid, req_wvalid}, 32'd0);

    // R12: offered in the cycle after accept
    cur_tag = "R12";
    done_dest = 16'h1234; done_tlabel = 6'h2A; done_ack = 3'd1; done_is_resp = 1'b0;
    done_bcast = 1'b0; done_valid = 1'b1;
    @(negedge clk);
    done_valid = 1'b0;
    check(req_wvalid === 1'b1 && req_wdata === {16'h1234, 6'h2A, 6'b0, 4'h1},
          "R12 R6 next-cycle offer", req_wdata, {16'h1234, 6'h2A, 6'b0, 4'h1});
    drain();

    // Every outcome, both classes, non-broadcast: R4 R6 R7 R8 R9
    for (int r = 0; r < 2; r++) begin
      for (int a = 0; a < 8; a++) begin
        cur_tag = (a == 0) ? "R4" : (a <= 2) ? "R6" : (a == 5) ? "R7" : (a <= 4) ? "R8" : "R9";
        send(r[0], 16'hFFC0 + 16'(a), 6'(a * 7 + r), 1'b0, 3'(a));
        check((r[0] ? rsp_wdata[3:0] : req_wdata[3:0]) === exp_code(1'b0, a),
              {cur_tag, " code"}, {28'b0, r[0] ? rsp_wdata[3:0] : req_wdata[3:0]},
              {28'b0, exp_code(1'b0, a)});
        drain();
      end
    end

    // Broadcast ignores outcome: R5
    cur_tag = "R5";
    for (int a = 0; a < 8; a++) begin
      send(a[0], 16'hFFFF, 6'(a), 1'b1, 3'(a));
      check((a[0] ? rsp_wdata[3:0] : req_wdata[3:0]) === 4'h1, "R5 broadcast code",
            {28'b0, a[0] ? rsp_wdata[3:0] : req_wdata[3:0]}, 32'h1);
      drain();
    end

    // Stall: queue not ready, word held, new events blocked: R10
    cur_tag = "R10";
    req_wready = 1'b0;
    send(1'b0, 16'h0BEE, 6'h11, 1'b0, 3'd2);
    done_dest = 16'h7777; done_valid = 1'b1;
    repeat (5) @(negedge clk);
    check(done_ready === 1'b0 && req_wdata === {16'h0BEE, 6'h11, 6'b0, 4'h2},
          "R10 held while stalled", req_wdata, {16'h0BEE, 6'h11, 6'b0, 4'h2});
    req_wready = 1'b1;
    while (!done_ready) @(negedge clk);
    @(negedge clk);
    done_valid = 1'b0;
    drain();

    // Random backpressure, back-to-back events: R1 R2 R10
    cur_tag = "R1";
    random_ready = 1'b1;
    for (int i = 0; i < 400; i++)
      send(lfsr[1], 16'(i * 37), 6'(i), (i % 11) == 0, 3'(i % 8));
    random_ready = 1'b0;
    @(negedge clk);
    req_wready = 1'b1; rsp_wready = 1'b1;
    drain();
    repeat (2) @(negedge clk);
    check(accepts == writes, "R1 accepts equal writes", 32'(writes), 32'(accepts));
    check(accepts > 400, "R1 accept count", 32'(accepts), 32'd401);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule